// File: doc/BRIEF.md
# Thermal Sensor Conversion Controller

This block controls an on-chip temperature sensor converter through a small register bank on a 32-bit register bus. Software powers the sensor up with an ordered enable write. It waits out a fixed stabilization interval and then triggers a conversion. In one conversion the block requests one, two, four or eight 12-bit samples from the sensor over a request/valid handshake. When the run ends it stores either the truncated average of the samples or the last sample in a result register.

When a conversion completes, the block raises a done flag. If comparison is armed, it also checks the stored value against a programmable lower and upper limit. A value strictly outside that window raises a compare flag. Both flags are cleared by writing one to a clear register. Each flag can be routed to a single interrupt line through its own enable bit. A continuous mode starts a new conversion as soon as each one ends. Powering down during a run aborts it.

Top module: `thermo_conv_ctrl`

## Requirements
- R1: After reset every readable register returns 0, `irq` is low and `smp_req` is low.
- R2: Power control is at 0x00, with bit0 sensor enable, bit1 converter power-down and bit2 SoC sensor enable. Bit0 is accepted only when bit2 is set in the same write. A write of 0x2 alone leaves the sensor powered off and reads back 0x2. The sensor counts as powered when bit0=1, bit2=1 and bit1=0.
- R3: Writing 1 to bit0 of 0x04 triggers a conversion. The trigger is ignored while the sensor is not powered, and during the first SETTLE_TICKS clock cycles after it becomes powered.
- R4: Status bit0 of 0x14 reads 1 from the cycle after an accepted trigger until the conversion ends. A trigger received while that bit is 1 is ignored and adds no samples.
- R5: Field bits[1:0] of the configuration register (0x08) sets the sample count per conversion to 2^field, so 3 gives 8 samples. Done flag bit0 of 0x30 is set only once the last sample has been received.
- R6: With configuration bit9 = 1, the result is the sum of the samples shifted right by field bits[1:0], truncated. With bit9 = 0, the result is the last sample of the run. The result is readable at 0x10, bits[11:0].
- R7: The result register changes only when a conversion completes.
- R8: When compare enable (bit0 of 0x18) is 1 at completion, compare flag bit1 of 0x30 is set if the result is below the lower limit (0x1C) or above the upper limit (0x20). A value equal to either limit does not set it.
- R9: Writing 1 to bit0 or bit1 of 0x38 clears the matching flag in 0x30. A flag set in the same cycle stays set.
- R10: `irq` is the OR of each flag in 0x30 ANDed with the bit in the same position of the enable register 0x34.
- R11: The configuration register reads back the written value masked to bits 1:0, 4 and 9. The limits read back 12 bits. The trigger and clear registers and unmapped addresses read 0.
- R12: While configuration bit4 is 1, a new conversion starts in the cycle after each completion, with no trigger.
- R13: Losing power during a conversion aborts it. The busy bit clears, `smp_req` drops, and no done flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| smp_req | output | 1 | Sample request to the sensor, held until valid |
| smp_vld | input | 1 | Sample valid from the sensor |
| smp_code | input | 12 | Sample code, qualified by `smp_vld` |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the sensor raises `smp_vld` only while `smp_req` is high, for one cycle at a time. They also assume that the bus presents at most one write per cycle. The bench's sensor model follows both rules: it waits for a request, answers after two cycles with a one-cycle valid pulse, and then looks for the request again. Register accesses go through tasks that drive a single write per bus cycle and read away from the clock edge.

// File: rtl/tsc_pkg.sv
// Shared constants for the thermal conversion controller: field widths,
// register byte offsets and bit positions that software decodes.
package tsc_pkg;
    localparam int CODE_W    = 12;
    localparam int SEL_W     = 2;
    localparam int MAX_SHIFT = (1 << SEL_W) - 1;
    localparam int SUM_W     = CODE_W + MAX_SHIFT;
    localparam int CNT_W     = MAX_SHIFT;

    localparam logic [7:0] A_PWR   = 8'h00;
    localparam logic [7:0] A_START = 8'h04;
    localparam logic [7:0] A_CFG   = 8'h08;
    localparam logic [7:0] A_RES   = 8'h10;
    localparam logic [7:0] A_STAT  = 8'h14;
    localparam logic [7:0] A_CMPEN = 8'h18;
    localparam logic [7:0] A_LO    = 8'h1C;
    localparam logic [7:0] A_HI    = 8'h20;
    localparam logic [7:0] A_ISTS  = 8'h30;
    localparam logic [7:0] A_IEN   = 8'h34;
    localparam logic [7:0] A_ICLR  = 8'h38;

    localparam int B_EN   = 0;
    localparam int B_PD   = 1;
    localparam int B_SOC  = 2;
    localparam int B_SCAN = 4;
    localparam int B_OSEL = 9;
endpackage

// File: rtl/tsc_settle.sv
// Stabilization gate: counts clock cycles while the sensor is powered and
// reports settled once SETTLE_TICKS have elapsed. Loss of power restarts it.
module tsc_settle #(
    parameter int SETTLE_TICKS = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic powered,
    output logic settled
);
    localparam int TW = $clog2(SETTLE_TICKS + 1);
    localparam logic [TW-1:0] LAST = TW'(SETTLE_TICKS);

    logic [TW-1:0] tick_q;

    // Count up to the limit while powered, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !powered) tick_q <= '0;
        else if (tick_q != LAST) tick_q <= tick_q + 1'b1;
    end

    assign settled = powered && (tick_q == LAST);

    assert_settle_after_power_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled) |-> $past(powered));
endmodule

// File: rtl/tsc_seq.sv
// Conversion sequencer: on start it requests 2^avg_sel samples one at a time,
// accumulates them, and on the last one emits a one-cycle fin pulse together
// with the averaged or last-sample value. Assumes smp_vld only while smp_req.
module tsc_seq
    import tsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [SEL_W-1:0]  avg_sel,
    input  logic              out_avg,
    input  logic              smp_vld,
    input  logic [CODE_W-1:0] smp_code,
    output logic              smp_req,
    output logic              busy,
    output logic              fin,
    output logic [CODE_W-1:0] value
);
    typedef enum logic {SQ_IDLE, SQ_REQ} sq_state_t;

    sq_state_t         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SUM_W-1:0]  acc_q;
    logic [SEL_W-1:0]  sel_q;
    logic              osel_q;
    logic [CNT_W:0]    n_full;
    logic [CNT_W-1:0]  last_idx;
    logic [SUM_W-1:0]  sum_next;
    logic [CODE_W-1:0] avg_next;

    // Derive the last sample index and the running sum for this sample.
    always_comb begin
        n_full   = (CNT_W + 1)'(1) << sel_q;
        last_idx = CNT_W'(n_full - 1'b1);
        sum_next = acc_q + SUM_W'(smp_code);
        avg_next = CODE_W'(sum_next >> sel_q);
    end

    // Sequence sample requests and produce the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            acc_q   <= '0;
            sel_q   <= '0;
            osel_q  <= 1'b0;
            fin     <= 1'b0;
            value   <= '0;
        end else begin
            fin <= 1'b0;
            if (abort) begin
                state_q <= SQ_IDLE;
                cnt_q   <= '0;
                acc_q   <= '0;
            end else if (state_q == SQ_IDLE) begin
                if (start) begin
                    state_q <= SQ_REQ;
                    cnt_q   <= '0;
                    acc_q   <= '0;
                    sel_q   <= avg_sel;
                    osel_q  <= out_avg;
                end
            end else if (smp_vld) begin
                if (cnt_q == last_idx) begin
                    state_q <= SQ_IDLE;
                    fin     <= 1'b1;
                    value   <= osel_q ? avg_next : smp_code;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    acc_q <= sum_next;
                end
            end
        end
    end

    assign smp_req = (state_q == SQ_REQ);
    assign busy    = (state_q == SQ_REQ);

    assert_count_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= last_idx));
    assert_fin_after_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> $past(smp_vld) && $past(busy));
endmodule

// File: rtl/tsc_window.sv
// Window comparator: flags a value strictly below lo or strictly above hi.
module tsc_window
    import tsc_pkg::*;
(
    input  logic [CODE_W-1:0] val,
    input  logic [CODE_W-1:0] lo,
    input  logic [CODE_W-1:0] hi,
    output logic              outside
);
    // Out-of-range test against both limits.
    always_comb outside = (val < lo) || (val > hi);
endmodule

// File: rtl/thermo_conv_ctrl.sv
// Thermal sensor conversion controller top: register bank, power gating,
// trigger qualification, result capture, flags and interrupt. Assumes at most
// one bus write per cycle; reads are combinational on bus_addr.
module thermo_conv_ctrl
    import tsc_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int SETTLE_TICKS = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              smp_req,
    input  logic              smp_vld,
    input  logic [11:0]       smp_code,
    output logic              irq
);
    logic              pwr_en_q, pwr_pd_q, pwr_soc_q;
    logic [SEL_W-1:0]  cfg_avg_q;
    logic              cfg_scan_q, cfg_osel_q, cmp_en_q;
    logic [CODE_W-1:0] lo_q, hi_q, result_q;
    logic [1:0]        sts_q, ien_q, sts_set, sts_clr;
    logic              powered, settled, busy, fin, outside, trig, start_go;
    logic [CODE_W-1:0] seq_value;

    function automatic logic hit(input logic [7:0] a);
        return bus_wr && (bus_addr == ADDR_W'(a));
    endfunction

    assign powered = pwr_en_q && pwr_soc_q && !pwr_pd_q;

    tsc_settle #(.SETTLE_TICKS(SETTLE_TICKS)) settle_i (
        .clk(clk), .rst_n(rst_n), .powered(powered), .settled(settled)
    );

    tsc_seq seq_i (
        .clk(clk), .rst_n(rst_n), .start(start_go), .abort(!settled),
        .avg_sel(cfg_avg_q), .out_avg(cfg_osel_q), .smp_vld(smp_vld),
        .smp_code(smp_code), .smp_req(smp_req), .busy(busy), .fin(fin),
        .value(seq_value)
    );

    tsc_window win_i (.val(seq_value), .lo(lo_q), .hi(hi_q), .outside(outside));

    // Qualify explicit and continuous-mode starts; compute flag set/clear.
    always_comb begin
        trig     = hit(A_START) && bus_wdata[0];
        start_go = settled && !busy && (trig || (cfg_scan_q && fin));
        sts_set  = {fin && cmp_en_q && outside, fin};
        sts_clr  = hit(A_ICLR) ? bus_wdata[1:0] : 2'b00;
    end

    // Register bank writes, result capture and flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_en_q <= 1'b0; pwr_pd_q <= 1'b0; pwr_soc_q <= 1'b0;
            cfg_avg_q <= '0; cfg_scan_q <= 1'b0; cfg_osel_q <= 1'b0;
            cmp_en_q <= 1'b0; lo_q <= '0; hi_q <= '0; result_q <= '0;
            sts_q <= '0; ien_q <= '0;
        end else begin
            if (hit(A_PWR)) begin
                pwr_soc_q <= bus_wdata[B_SOC];
                pwr_pd_q  <= bus_wdata[B_PD];
                pwr_en_q  <= bus_wdata[B_EN] && bus_wdata[B_SOC];
            end
            if (hit(A_CFG)) begin
                cfg_avg_q  <= bus_wdata[SEL_W-1:0];
                cfg_scan_q <= bus_wdata[B_SCAN];
                cfg_osel_q <= bus_wdata[B_OSEL];
            end
            if (hit(A_CMPEN)) cmp_en_q <= bus_wdata[0];
            if (hit(A_LO))    lo_q     <= bus_wdata[CODE_W-1:0];
            if (hit(A_HI))    hi_q     <= bus_wdata[CODE_W-1:0];
            if (hit(A_IEN))   ien_q    <= bus_wdata[1:0];
            if (fin)          result_q <= seq_value;
            sts_q <= (sts_q & ~sts_clr) | sts_set;
        end
    end

    // Read multiplexer; unused bits and addresses return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(A_PWR):   bus_rdata = {29'd0, pwr_soc_q, pwr_pd_q, pwr_en_q};
            ADDR_W'(A_CFG):   bus_rdata = {22'd0, cfg_osel_q, 4'd0, cfg_scan_q, 2'd0, cfg_avg_q};
            ADDR_W'(A_RES):   bus_rdata = 32'(result_q);
            ADDR_W'(A_STAT):  bus_rdata = {31'd0, busy};
            ADDR_W'(A_CMPEN): bus_rdata = {31'd0, cmp_en_q};
            ADDR_W'(A_LO):    bus_rdata = 32'(lo_q);
            ADDR_W'(A_HI):    bus_rdata = 32'(hi_q);
            ADDR_W'(A_ISTS):  bus_rdata = {30'd0, sts_q};
            ADDR_W'(A_IEN):   bus_rdata = {30'd0, ien_q};
            default:          bus_rdata = '0;
        endcase
    end

    assign irq = |(sts_q & ien_q);

    assert_soc_with_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_en_q |-> pwr_soc_q);
    assert_start_needs_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(settled));
    assert_result_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(result_q));
    assert_cmp_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[1]) |-> $past(fin) && $past(cmp_en_q));
    assert_abort_on_power_loss_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !settled |=> !busy);
endmodule

// File: tb/thermo_conv_ctrl_tb_top.sv
// Directed bench for the thermal conversion controller.
module thermo_conv_ctrl_tb_top;
    localparam int SETTLE = 120;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        smp_req;
    logic        smp_vld = 1'b0;
    logic [11:0] smp_code = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int tb_idx = 0;
    int tb_nvld = 0;
    logic [11:0] tb_codes [8];

    always #2.5 clk = ~clk;

    thermo_conv_ctrl #(.ADDR_W(8), .SETTLE_TICKS(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_req(smp_req),
        .smp_vld(smp_vld), .smp_code(smp_code), .irq(irq)
    );

    // Sensor model: answer each request after two cycles with a one-cycle valid.
    initial begin
        forever begin
            @(negedge clk);
            if (smp_req && !smp_vld) begin
                repeat (2) @(negedge clk);
                smp_vld  = 1'b1;
                smp_code = tb_codes[tb_idx];
                tb_idx   = (tb_idx + 1) % 8;
                tb_nvld++;
                @(negedge clk);
                smp_vld = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic load_codes(input int c0, c1, c2, c3, c4, c5, c6, c7);
        tb_codes[0] = 12'(c0); tb_codes[1] = 12'(c1); tb_codes[2] = 12'(c2);
        tb_codes[3] = 12'(c3); tb_codes[4] = 12'(c4); tb_codes[5] = 12'(c5);
        tb_codes[6] = 12'(c6); tb_codes[7] = 12'(c7);
        tb_idx = 0; tb_nvld = 0;
    endtask

    task automatic wait_done(output bit seen);
        logic [31:0] v;
        seen = 1'b0;
        for (int i = 0; i < 200; i++) begin
            rd(8'h30, v);
            if (v[0]) begin seen = 1'b1; break; end
        end
    endtask

    task automatic power_up();
        wr(8'h00, 32'h5);
        repeat (SETTLE + 5) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); chk("R1 pwr", v, 0);
        rd(8'h08, v); chk("R1 cfg", v, 0);
        rd(8'h10, v); chk("R1 result", v, 0);
        rd(8'h14, v); chk("R1 status", v, 0);
        rd(8'h30, v); chk("R1 flags", v, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 smp_req", 32'(smp_req), 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); chk("R11 cfg mask", v, 32'h213);
        wr(8'h1C, 32'h000F_FFFF); rd(8'h1C, v); chk("R11 lo width", v, 32'hFFF);
        wr(8'h04, 32'h0);         rd(8'h04, v); chk("R11 start reads 0", v, 0);
        rd(8'h0C, v); chk("R11 unmapped", v, 0);
        wr(8'h08, 32'h0);
    endtask

    task automatic t_power_rules();
        logic [31:0] v;
        wr(8'h04, 32'h1); repeat (3) @(negedge clk);
        rd(8'h14, v); chk("R3 trigger unpowered", v, 0);
        wr(8'h00, 32'h1); rd(8'h00, v); chk("R2 enable without soc", v, 0);
        wr(8'h00, 32'h5); rd(8'h00, v); chk("R2 enable with soc", v, 32'h5);
        wr(8'h04, 32'h1); repeat (3) @(negedge clk);
        rd(8'h14, v); chk("R3 trigger while settling", v, 0);
        repeat (SETTLE + 5) @(negedge clk);
    endtask

    task automatic t_average();
        logic [31:0] v; bit seen;
        load_codes(100, 200, 300, 400, 500, 600, 700, 801);
        wr(8'h08, 32'h203);
        wr(8'h04, 32'h1);
        rd(8'h14, v); chk("R4 busy after trigger", v, 1);
        wr(8'h04, 32'h1);
        rd(8'h10, v); chk("R7 result held mid-run", v, 0);
        wait_done(seen);
        chk("R5 done seen", 32'(seen), 1);
        chk("R5 eight samples before done", 32'(tb_nvld), 8);
        rd(8'h10, v); chk("R6 truncated average", v, 450);
        repeat (30) @(negedge clk);
        chk("R4 busy trigger ignored", 32'(tb_nvld), 8);
        rd(8'h14, v); chk("R4 idle after run", v, 0);
        wr(8'h38, 32'h3);
        rd(8'h30, v); chk("R9 clear done", v, 0);
    endtask

    task automatic t_last_and_single();
        logic [31:0] v; bit seen;
        load_codes(100, 200, 300, 400, 500, 600, 700, 801);
        wr(8'h08, 32'h003);
        wr(8'h04, 32'h1); wait_done(seen);
        rd(8'h10, v); chk("R6 last sample", v, 801);
        wr(8'h38, 32'h1);
        load_codes(77, 0, 0, 0, 0, 0, 0, 0);
        wr(8'h08, 32'h200);
        wr(8'h04, 32'h1); wait_done(seen);
        chk("R5 one sample", 32'(tb_nvld), 1);
        rd(8'h10, v); chk("R6 one-sample average", v, 77);
        wr(8'h38, 32'h1);
    endtask

    task automatic run_cmp(input int code, input logic [31:0] exp_flag, input string tag);
        logic [31:0] v; bit seen;
        load_codes(code, code, code, code, code, code, code, code);
        wr(8'h04, 32'h1); wait_done(seen);
        rd(8'h30, v); chk(tag, v[1], exp_flag);
        wr(8'h38, 32'h3);
    endtask

    task automatic t_compare();
        logic [31:0] v; bit seen;
        wr(8'h08, 32'h203);
        wr(8'h1C, 300); wr(8'h20, 600);
        load_codes(250, 250, 250, 250, 250, 250, 250, 250);
        wr(8'h04, 32'h1); wait_done(seen);
        rd(8'h30, v); chk("R8 disabled no flag", v[1], 0);
        wr(8'h38, 32'h3);
        wr(8'h18, 32'h1);
        run_cmp(450, 0, "R8 inside window");
        run_cmp(300, 0, "R8 at lower limit");
        run_cmp(600, 0, "R8 at upper limit");
        run_cmp(601, 1, "R8 above upper");
        wr(8'h34, 32'h2);
        load_codes(250, 250, 250, 250, 250, 250, 250, 250);
        wr(8'h04, 32'h1); wait_done(seen);
        rd(8'h30, v); chk("R8 below lower", v[1], 1);
        chk("R10 irq compare", 32'(irq), 1);
        wr(8'h38, 32'h2);
        rd(8'h30, v); chk("R9 clear compare only", v, 1);
        chk("R10 irq after clear", 32'(irq), 0);
        wr(8'h34, 32'h1);
        chk("R10 irq done enabled", 32'(irq), 1);
        wr(8'h34, 32'h0);
        chk("R10 irq masked", 32'(irq), 0);
        wr(8'h38, 32'h3); wr(8'h18, 32'h0);
    endtask

    task automatic t_scan();
        logic [31:0] v; bit seen;
        load_codes(5, 5, 5, 5, 5, 5, 5, 5);
        wr(8'h08, 32'h010);
        wr(8'h04, 32'h1); wait_done(seen);
        wr(8'h38, 32'h1);
        wait_done(seen);
        chk("R12 second run without trigger", 32'(seen), 1);
        wr(8'h08, 32'h0);
        repeat (20) @(negedge clk);
        rd(8'h14, v); chk("R12 stops when cleared", v, 0);
        wr(8'h38, 32'h3);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        load_codes(9, 9, 9, 9, 9, 9, 9, 9);
        wr(8'h08, 32'h203);
        wr(8'h04, 32'h1);
        repeat (4) @(negedge clk);
        wr(8'h00, 32'h2);
        rd(8'h00, v); chk("R2 power-down write", v, 32'h2);
        rd(8'h14, v); chk("R13 busy cleared", v, 0);
        repeat (40) @(negedge clk);
        rd(8'h30, v); chk("R13 no done", v, 0);
        chk("R13 smp_req low", 32'(smp_req), 0);
        wr(8'h04, 32'h1); repeat (3) @(negedge clk);
        rd(8'h14, v); chk("R3 trigger after power-down", v, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) tb_codes[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_power_rules();
        t_average();
        t_last_and_single();
        t_compare();
        t_scan();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule